// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block divides a fast input clock down to one output clock. The ratio is programmed as two separate phase lengths. The output stays high for a programmed number of input cycles and then stays low for a second programmed number. The division ratio is the sum of the two counts. A clock synthesizer uses one such divider per output, placed after its oscillator.

Two control flags sit beside the counts. The first is a bypass, which routes the input clock straight to the output and is used for a ratio of one. The second is an odd-ratio flag. When it is set, the output falls half an input cycle early, so an odd ratio still gives a 50 % duty cycle.

Software writes the count word and the control pair at any time. Each write goes into a staging copy. The active settings are replaced from that copy only when the current output period ends, so a change never produces a short pulse. Reset is asynchronous and active low, and its release is synchronised to the input clock.

Top module: `hl_clk_div`

## Requirements
- R1: With bypass clear, each output period is high for H input cycles and then low for L input cycles, so the period is H+L input cycles. This holds when the odd flag is clear.
- R2: The count word carries H in bits [15:8] and L in bits [7:0]. It is captured on a rising edge of the input clock where `cnt_we_i` is high.
- R3: The control pair carries bypass in bit 0 and the odd flag in bit 1. It is captured on a rising edge where `ctl_we_i` is high.
- R4: While the active bypass flag is set and the divider is running, the output equals the input clock.
- R5: While the active odd flag is set, the output falls half an input cycle before the end of the high phase. The high time becomes H−0.5 input cycles and the low time becomes L+0.5 input cycles.
- R6: A high or low count of zero behaves exactly like a count of one.
- R7: A written count word or control pair takes effect only at the first period boundary after the write. A period boundary is the rising edge that ends the low phase. Until then, the period in progress keeps its old settings.
- R8: The output is low while reset is asserted and for the first two input rising edges after release. It goes high in the high phase on the third rising edge.
- R9: Reset sets the staged and active count words to 0x0101 and the control pair to bypass set and odd clear. With no writes, the output therefore follows the input clock once running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_we_i | input | 1 | Write strobe for the count word |
| cnt_i | input | 16 | Count word: H in [15:8], L in [7:0] |
| ctl_we_i | input | 1 | Write strobe for the control pair |
| ctl_i | input | 2 | Control pair: bit 0 bypass, bit 1 odd |
| clk_o | output | 1 | Divided (or bypassed) output clock |

## Verification
Each half cycle of the input clock is sampled at its midpoint and compared against an expected output level. A phase counter that is off by one shows up within one output period, as a high or low run one input cycle too long or too short. A staging error, where the active settings load early or late, shows up in the first period after the write. There, the duty and the period differ from what the boundary rule predicts. A wrong negative-edge stage misplaces the odd-ratio falling edge by half a cycle, which the low-half sample of the last high cycle catches at once. Counts of output-high samples over whole numbers of periods give an alignment-free cross-check of the duty cycle.

// File: rtl/hl_div_pkg.sv
package hl_div_pkg;

  // default width of one phase count
  localparam int DEF_CNT_W = 8;

  // control pair: bit 1 odd-ratio, bit 0 bypass
  typedef struct packed {
    logic odd;
    logic byp;
  } div_ctl_t;

  localparam div_ctl_t CTL_RST = '{odd: 1'b0, byp: 1'b1};

endpackage

// File: rtl/hl_div_rst_sync.sv
module hl_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/hl_div_cfg.sv
module hl_div_cfg
  import hl_div_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [2*CNT_W-1:0] cnt_i,
  input  logic             ctl_we_i,
  input  div_ctl_t         ctl_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] act_hi_o,
  output logic [CNT_W-1:0] act_lo_o,
  output div_ctl_t         act_ctl_o
);

  localparam logic [CNT_W-1:0]   ONE     = CNT_W'(1);
  localparam logic [2*CNT_W-1:0] CNT_RST = {ONE, ONE};

  logic [2*CNT_W-1:0] stg_cnt_q;
  div_ctl_t           stg_ctl_q;
  logic [2*CNT_W-1:0] act_cnt_q;
  div_ctl_t           act_ctl_q;

  // staging copies, written by software strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_cnt_q <= CNT_RST;
      stg_ctl_q <= CTL_RST;
    end else begin
      if (cnt_we_i) begin
        stg_cnt_q <= cnt_i;
      end
      if (ctl_we_i) begin
        stg_ctl_q <= ctl_i;
      end
    end
  end

  // active copies, refreshed only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_cnt_q <= CNT_RST;
      act_ctl_q <= CTL_RST;
    end else if (load_i) begin
      act_cnt_q <= stg_cnt_q;
      act_ctl_q <= stg_ctl_q;
    end
  end

  assign act_hi_o  = act_cnt_q[2*CNT_W-1:CNT_W];
  assign act_lo_o  = act_cnt_q[CNT_W-1:0];
  assign act_ctl_o = act_ctl_q;

endmodule

// File: rtl/hl_div_core.sv
module hl_div_core
  import hl_div_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] act_hi_i,
  input  logic [CNT_W-1:0] act_lo_i,
  input  logic             act_odd_i,
  output logic             started_o,
  output logic             phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             fall_req_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             started_q, started_d;
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hi_eff, lo_eff;
  logic             hi_last, lo_last;

  always_comb begin
    hi_eff  = (act_hi_i == '0) ? ONE : act_hi_i;
    lo_eff  = (act_lo_i == '0) ? ONE : act_lo_i;
    hi_last = phase_q && (cnt_q == hi_eff - ONE);
    lo_last = started_q && !phase_q && (cnt_q == lo_eff - ONE);
  end

  always_comb begin
    started_d = started_q;
    phase_d   = phase_q;
    cnt_d     = cnt_q + ONE;
    if (!started_q) begin
      started_d = 1'b1;
      phase_d   = 1'b1;
      cnt_d     = '0;
    end else if (hi_last) begin
      phase_d = 1'b0;
      cnt_d   = '0;
    end else if (lo_last) begin
      phase_d = 1'b1;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      phase_q   <= 1'b0;
      cnt_q     <= '0;
    end else begin
      started_q <= started_d;
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
    end
  end

  assign started_o  = started_q;
  assign phase_o    = phase_q;
  assign cnt_o      = cnt_q;
  assign load_o     = !started_q || lo_last;
  assign fall_req_o = hi_last && act_odd_i;

endmodule

// File: rtl/hl_div_shape.sv
module hl_div_shape (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic started_i,
  input  logic phase_i,
  input  logic fall_req_i,
  input  logic byp_i,
  output logic fall_o,
  output logic clk_o
);

  logic fall_q;

  // negative-edge stage: pulls the output low half a cycle early
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= fall_req_i;
    end
  end

  always_comb begin
    if (byp_i) begin
      clk_o = clk_i & started_i;
    end else begin
      clk_o = phase_i & ~fall_q;
    end
  end

  assign fall_o = fall_q;

endmodule

// File: rtl/hl_clk_div.sv
module hl_clk_div
  import hl_div_pkg::*;
#(
  parameter int CNT_W      = DEF_CNT_W,
  parameter int RST_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_we_i,
  input  logic [2*CNT_W-1:0] cnt_i,
  input  logic               ctl_we_i,
  input  logic [1:0]         ctl_i,
  output logic               clk_o
);

  logic             rst_sync_n;
  logic             started_w;
  logic             phase_w;
  logic [CNT_W-1:0] cnt_w;
  logic             load_w;
  logic             fall_req_w;
  logic             fall_w;
  logic [CNT_W-1:0] act_hi_w;
  logic [CNT_W-1:0] act_lo_w;
  div_ctl_t         act_ctl_w;
  logic             act_odd_w;

  hl_div_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  hl_div_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .cnt_we_i  (cnt_we_i),
    .cnt_i     (cnt_i),
    .ctl_we_i  (ctl_we_i),
    .ctl_i     (div_ctl_t'(ctl_i)),
    .load_i    (load_w),
    .act_hi_o  (act_hi_w),
    .act_lo_o  (act_lo_w),
    .act_ctl_o (act_ctl_w)
  );

  assign act_odd_w = act_ctl_w.odd;

  hl_div_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .act_hi_i   (act_hi_w),
    .act_lo_i   (act_lo_w),
    .act_odd_i  (act_odd_w),
    .started_o  (started_w),
    .phase_o    (phase_w),
    .cnt_o      (cnt_w),
    .load_o     (load_w),
    .fall_req_o (fall_req_w)
  );

  hl_div_shape u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .started_i  (started_w),
    .phase_i    (phase_w),
    .fall_req_i (fall_req_w),
    .byp_i      (act_ctl_w.byp),
    .fall_o     (fall_w),
    .clk_o      (clk_o)
  );

endmodule

// File: rtl/hl_clk_div_chk.sv
module hl_clk_div_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             started,
  input logic             phase,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_hi,
  input logic [CNT_W-1:0] act_lo,
  input logic             act_odd,
  input logic             fall
);

  logic [CNT_W-1:0] hi_lim;
  logic [CNT_W-1:0] lo_lim;

  always_comb begin
    hi_lim = (act_hi == '0) ? CNT_W'(1) : act_hi;
    lo_lim = (act_lo == '0) ? CNT_W'(1) : act_lo;
  end

  AST_HIGH_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase |-> (cnt < hi_lim)); // R6

  AST_LOW_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !phase) |-> (cnt < lo_lim)); // R1

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && $past(started) && !$rose(phase)) |-> $stable({act_hi, act_lo, act_odd})); // R7

  AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(started) |-> phase); // R8

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> !phase); // R8

  AST_FALL_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |-> (act_odd && phase)); // R5

endmodule

bind hl_clk_div hl_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .started (started_w),
  .phase   (phase_w),
  .cnt     (cnt_w),
  .act_hi  (act_hi_w),
  .act_lo  (act_lo_w),
  .act_odd (act_odd_w),
  .fall    (fall_w)
);

// File: tb/test_hl_clk_div.sv
module test_hl_clk_div;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_we;
  logic [15:0] cnt_word;
  logic        ctl_we;
  logic [1:0]  ctl_word;
  logic        clk_out;

  always #10 clk = ~clk;

  hl_clk_div i_hl_clk_div (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cnt_we_i (cnt_we),
    .cnt_i    (cnt_word),
    .ctl_we_i (ctl_we),
    .ctl_i    (ctl_word),
    .clk_o    (clk_out)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    hi_seen = 0;
  bit    done = 1'b0;
  string cur_req = "R8";

  // spec model state
  int  m_st, m_ph, m_cnt;
  int  a_hi, a_lo, a_byp, a_odd;
  int  s_hi, s_lo, s_byp, s_odd;
  logic e_hi, e_lo;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  // one rising edge of the model, using the inputs present before it
  task automatic model_step();
    int he, le;
    bit load;
    he = eff(a_hi);
    le = eff(a_lo);
    load = 1'b0;
    if (m_st == 0) begin
      load = 1'b1; m_st = 1; m_ph = 1; m_cnt = 0;
    end else if (m_ph == 1 && m_cnt == he - 1) begin
      m_ph = 0; m_cnt = 0;
    end else if (m_ph == 0 && m_cnt == le - 1) begin
      m_ph = 1; m_cnt = 0; load = 1'b1;
    end else begin
      m_cnt++;
    end
    if (load) begin
      a_hi = s_hi; a_lo = s_lo; a_byp = s_byp; a_odd = s_odd;
    end
    if (cnt_we) begin
      s_hi = int'(cnt_word[15:8]);   // R2
      s_lo = int'(cnt_word[7:0]);
    end
    if (ctl_we) begin
      s_byp = int'(ctl_word[0]);     // R3
      s_odd = int'(ctl_word[1]);
    end
    e_hi = (a_byp == 1) ? 1'b1 : (m_ph == 1);
    e_lo = (a_byp == 0) && (m_ph == 1) && !((a_odd == 1) && (m_cnt == eff(a_hi) - 1));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #5;
    chk(clk_out, e_hi, "high half");
    if (clk_out === 1'b1) hi_seen++;
    #10;
    chk(clk_out, e_lo, "low half");
    if (clk_out === 1'b1) hi_seen++;
    cnt_we = 1'b0;
    ctl_we = 1'b0;
  endtask

  task automatic cyc_idle();
    @(posedge clk);
    #5;
    chk(clk_out, 1'b0, "idle high half");
    #10;
    chk(clk_out, 1'b0, "idle low half");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic prog(input logic [7:0] h, input logic [7:0] l, input logic byp, input logic odd);
    cnt_word = {h, l};
    cnt_we   = 1'b1;
    ctl_word = {odd, byp};
    ctl_we   = 1'b1;
  endtask

  // count high half-samples over n cycles (whole periods)
  task automatic measure(input int n, input int exp, input string what);
    hi_seen = 0;
    run(n);
    chk_int(hi_seen, exp, what);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; cnt_we = 1'b0; ctl_we = 1'b0; cnt_word = '0; ctl_word = '0;
    m_st = 0; m_ph = 0; m_cnt = 0;
    a_hi = 1; a_lo = 1; a_byp = 1; a_odd = 0;
    s_hi = 1; s_lo = 1; s_byp = 1; s_odd = 0;

    cur_req = "R8";
    repeat (3) cyc_idle();
    #15;
    rst_n = 1'b1;
    repeat (2) cyc_idle();

    cur_req = "R9";
    run(2);
    measure(6, 6, "reset default follows input");

    cur_req = "R2";
    prog(8'd2, 8'd2, 1'b0, 1'b0);
    run(10);
    cur_req = "R1";
    measure(8, 8, "ratio 4 duty");

    prog(8'd3, 8'd1, 1'b0, 1'b0);
    run(10);
    measure(8, 12, "high 3 low 1");

    cur_req = "R5";
    prog(8'd3, 8'd2, 1'b0, 1'b1);
    run(12);
    measure(10, 10, "odd ratio 5 half duty");
    prog(8'd1, 8'd1, 1'b0, 1'b1);
    run(6);
    measure(4, 2, "odd flag on ratio 2");

    cur_req = "R6";
    prog(8'd0, 8'd0, 1'b0, 1'b0);
    run(6);
    measure(4, 4, "zero counts as one");
    prog(8'd0, 8'd3, 1'b0, 1'b0);
    run(8);
    measure(8, 4, "zero high count");

    cur_req = "R7";
    prog(8'd6, 8'd6, 1'b0, 1'b0);
    run(30);
    run(3);
    prog(8'd1, 8'd1, 1'b0, 1'b0);
    run(14);
    run(4);
    prog(8'd7, 8'd2, 1'b0, 1'b0);
    run(20);

    cur_req = "R4";
    ctl_word = 2'b01; ctl_we = 1'b1;
    run(20);
    measure(8, 8, "bypass tracks input");

    cur_req = "R3";
    ctl_word = 2'b10; ctl_we = 1'b1;
    run(20);

    cur_req = "R1";
    for (int it = 0; it < 300; it++) begin
      int c, lo, hi;
      c = 1 + int'($urandom_range(19));
      lo = c / 2;
      hi = lo + (c % 2);
      if ($urandom_range(9) == 0) begin
        prog(8'($urandom_range(3)), 8'($urandom_range(3)), 1'b0, 1'($urandom_range(1)));
      end else if (c == 1) begin
        prog(8'd1, 8'd0, 1'b1, 1'b1);
      end else begin
        prog(8'(hi), 8'(lo), 1'b0, 1'(c % 2));
      end
      run(1 + int'($urandom_range(40)));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule